// File: doc/BRIEF.md
# Virtual Processor-Identity Register Access Controller

This block keeps a 64-bit virtual processor-identity value for a guest and judges every system-register access that names it. The same judgement covers reads of the physical identity register that the virtual copy stands in for. For each request the block looks at the current privilege level and the virtualization controls. It then gives one of six outcomes: data returned, write done, write ignored, redirect to memory, trap, or undefined. It also gives the trap's target level and syndrome class, or the memory offset of a redirected access.

A request is a one-cycle strobe with an access encoding, a read/write flag and write data. A separate flag marks the 32-bit coprocessor access space. The outcome appears one cycle later, so the pipeline can act on it: it can take the exception, perform the memory access, or write the returned data to the destination register. Exception entry and the backing memory are not part of this block.

Top module: `vid_access_ctl`

## Requirements
- R1: Each request strobe produces exactly one response strobe in the next cycle, carrying an outcome code: 0 = data, 1 = write done, 2 = write ignored, 3 = memory redirect, 4 = trap, 5 = undefined. When the outcome is not data, the read data is zero. No response appears in the reset state.
- R2: A write stores the value with bits 63:40 and 29:25 forced to zero and bit 31 forced to one. Bits 39:32, 30, 24 and 23:0 are kept as written.
- R3: After reset, the virtual register holds the physical identity input, with the fixed bits of R2 applied.
- R4: The encoding is {op0[15:14], op1[13:11], CRn[10:7], CRm[6:3], op2[2:0]}. The virtual register is 3/4/0/0/5 and the physical register is 3/0/0/0/5. Any access to the virtual register at level 0, and any access with an unmatched encoding, is undefined.
- R5: At level 1, with the hypervisor enabled and both nested bits set, a virtual access is a memory redirect at offset 0x050 and leaves the register unchanged.
- R6: At level 1, with the hypervisor enabled and only the primary nested bit set, a virtual access traps to level 2 with class 0x18. Any other level-1 virtual access is undefined.
- R7: At level 2, virtual reads return the register and virtual writes update it.
- R8: At level 3, when the hypervisor level is absent, virtual reads return the raw physical value and writes are ignored. When it is present, access is direct.
- R9: At level 1, a physical read with the hypervisor enabled in 64-bit mode traps to level 2 with class 0x18. This happens when the fine-grained read-trap bit is set and either level 3 is absent or the top-level trap enable is set.
- R10: Any other level-1 physical read returns the virtual register when the hypervisor is enabled in 64-bit mode, and the raw physical value otherwise.
- R11: At level 0, a physical read is undefined without the ID-trap feature. With the feature, it traps with class 0x18: to level 2 when the hypervisor is enabled in 64-bit mode and the trap-general bit is set, otherwise to level 1.
- R12: A coprocessor read (flag set, encoding bits 12:0 = 0/0/0/5) at level 1 behaves as follows. With the hypervisor enabled, it traps to level 2 with class 0x03 if the coprocessor trap bit is set, and otherwise returns the virtual low 32 bits. Without the hypervisor, it returns the physical low 32 bits. At levels 2 and 3 it returns the physical low 32 bits. Upper bits are zero.
- R13: Physical reads at levels 2 and 3 return the raw physical value. Writes to the physical or coprocessor encodings are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqCp32 | input | 1 | Request is in the 32-bit coprocessor space |
| reqEnc | input | 16 | Access encoding |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 64 | Write data |
| curEl | input | 2 | Current privilege level |
| hypImpl | input | 1 | Hypervisor level implemented |
| hypEnabled | input | 1 | Hypervisor level enabled in the current state |
| hyp32 | input | 1 | Hypervisor level runs in 32-bit mode |
| nvBit | input | 1 | Primary nested-virtualization bit |
| nv2Bit | input | 1 | Secondary nested-virtualization bit |
| tgeBit | input | 1 | Trap-general bit |
| fgtRead | input | 1 | Fine-grained read-trap bit for the identity register |
| el3Impl | input | 1 | Level 3 implemented |
| fgtEnable | input | 1 | Top-level fine-grained trap enable |
| idTrapFeat | input | 1 | ID-trap feature present |
| cpTrap | input | 1 | Coprocessor trap bit |
| physId | input | 64 | Physical identity value |
| rspValid | output | 1 | Response strobe |
| rspCode | output | 3 | Outcome code |
| rspRdata | output | 64 | Read data |
| rspTargetEl | output | 2 | Trap target level |
| rspClass | output | 6 | Trap syndrome class |
| rspMemOff | output | 12 | Memory redirect offset |

## Verification
The bench goes after the places where the privilege and control rules fork:
- Level 1 with only the secondary nested bit set must give undefined. A design that tests the bits loosely would redirect or trap here.
- The redirected write must not change the register. A design that gets this wrong would change the value seen by the next direct read.
- The fine-grained trap must depend on level 3 being absent or the top-level enable being set. A design that ignores either condition would trap, or pass, a physical read at level 1 wrongly.
- Writes of all-ones and all-zeros expose any reserved bit that is not forced.
- The level-3 read with no hypervisor exposes a design that returns the virtual copy instead of the raw physical value.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int ID_W = 64;
  localparam int ENC_W = 16;

  typedef enum logic [2:0] {
    OC_DATA  = 3'd0,
    OC_WDONE = 3'd1,
    OC_WIGN  = 3'd2,
    OC_MEM   = 3'd3,
    OC_TRAP  = 3'd4,
    OC_UNDEF = 3'd5
  } outcome_e;

  typedef enum logic [2:0] {
    RS_NONE    = 3'd0,
    RS_VIRT    = 3'd1,
    RS_PHYS    = 3'd2,
    RS_VIRT_LO = 3'd3,
    RS_PHYS_LO = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   wrEn;
    rdSel_e rdSel;
  } dpCmd_t;

  // Bits kept from written data: affinity 3, uniprocessor, multithread, affinity 2..0
  localparam logic [ID_W-1:0] KEEP_MASK = {24'h0, 8'hFF, 1'b0, 1'b1, 5'h0, 1'b1, 24'hFF_FFFF};
  localparam logic [ID_W-1:0] ONE_MASK  = {32'h0, 1'b1, 31'h0};

  localparam logic [ENC_W-1:0] ENC_VIRT = {2'd3, 3'd4, 4'd0, 4'd0, 3'd5};
  localparam logic [ENC_W-1:0] ENC_PHYS = {2'd3, 3'd0, 4'd0, 4'd0, 3'd5};
  localparam logic [12:0]      ENC_CP   = {3'd0, 4'd0, 4'd0, 3'd5};

  function automatic logic [ID_W-1:0] fixBits(input logic [ID_W-1:0] v);
    return (v & KEEP_MASK) | ONE_MASK;
  endfunction
endpackage

// File: rtl/vid_ctrl.sv
module vid_ctrl
  import vid_pkg::*;
#(
  parameter int CLASS_W = 6,
  parameter int OFF_W = 12,
  parameter logic [CLASS_W-1:0] CLS_SYS = 6'h18,
  parameter logic [CLASS_W-1:0] CLS_CP = 6'h03,
  parameter logic [OFF_W-1:0] MEM_OFF = 12'h050
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqCp32,
  input  logic [ENC_W-1:0]   reqEnc,
  input  logic               reqWrite,
  input  logic [1:0]         curEl,
  input  logic               hypImpl,
  input  logic               hypEnabled,
  input  logic               hyp32,
  input  logic               nvBit,
  input  logic               nv2Bit,
  input  logic               tgeBit,
  input  logic               fgtRead,
  input  logic               el3Impl,
  input  logic               fgtEnable,
  input  logic               idTrapFeat,
  input  logic               cpTrap,
  output dpCmd_t             dpCmd,
  output logic               rspValid,
  output logic [2:0]         rspCode,
  output logic [1:0]         rspTargetEl,
  output logic [CLASS_W-1:0] rspClass,
  output logic [OFF_W-1:0]   rspMemOff
);
  outcome_e           oc;
  logic [1:0]         tgt;
  logic [CLASS_W-1:0] cls;
  logic [OFF_W-1:0]   off;
  dpCmd_t             cmd;

  logic isVirt, isPhys, isCp, hyp64;
  assign isVirt = !reqCp32 && (reqEnc == ENC_VIRT);
  assign isPhys = !reqCp32 && (reqEnc == ENC_PHYS);
  assign isCp   = reqCp32 && (reqEnc[12:0] == ENC_CP);
  assign hyp64  = hypEnabled && !hyp32;

  always_comb begin
    oc = OC_UNDEF;
    tgt = 2'd0;
    cls = '0;
    off = '0;
    cmd.wrEn = 1'b0;
    cmd.rdSel = RS_NONE;
    if (isVirt) begin
      if (curEl == 2'd1) begin
        if (hypEnabled && nvBit && nv2Bit) begin
          oc = OC_MEM;
          off = MEM_OFF;
        end else if (hypEnabled && nvBit) begin
          oc = OC_TRAP;
          tgt = 2'd2;
          cls = CLS_SYS;
        end
      end else if (curEl == 2'd3 && !hypImpl) begin
        if (reqWrite) oc = OC_WIGN;
        else begin
          oc = OC_DATA;
          cmd.rdSel = RS_PHYS;
        end
      end else if (curEl != 2'd0) begin
        if (reqWrite) begin
          oc = OC_WDONE;
          cmd.wrEn = 1'b1;
        end else begin
          oc = OC_DATA;
          cmd.rdSel = RS_VIRT;
        end
      end
    end else if (isPhys && !reqWrite) begin
      if (curEl == 2'd0) begin
        if (idTrapFeat) begin
          oc = OC_TRAP;
          cls = CLS_SYS;
          tgt = (hyp64 && tgeBit) ? 2'd2 : 2'd1;
        end
      end else if (curEl == 2'd1) begin
        if (hyp64 && fgtRead && (!el3Impl || fgtEnable)) begin
          oc = OC_TRAP;
          tgt = 2'd2;
          cls = CLS_SYS;
        end else begin
          oc = OC_DATA;
          cmd.rdSel = hyp64 ? RS_VIRT : RS_PHYS;
        end
      end else begin
        oc = OC_DATA;
        cmd.rdSel = RS_PHYS;
      end
    end else if (isCp && !reqWrite) begin
      if (curEl == 2'd1) begin
        if (hypEnabled && cpTrap) begin
          oc = OC_TRAP;
          tgt = 2'd2;
          cls = CLS_CP;
        end else begin
          oc = OC_DATA;
          cmd.rdSel = hypEnabled ? RS_VIRT_LO : RS_PHYS_LO;
        end
      end else if (curEl != 2'd0) begin
        oc = OC_DATA;
        cmd.rdSel = RS_PHYS_LO;
      end
    end
  end

  always_comb begin
    dpCmd.wrEn = reqValid && cmd.wrEn;
    dpCmd.rdSel = reqValid ? cmd.rdSel : RS_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode <= '0;
      rspTargetEl <= '0;
      rspClass <= '0;
      rspMemOff <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspCode <= oc;
        rspTargetEl <= tgt;
        rspClass <= cls;
        rspMemOff <= off;
      end
    end
  end
endmodule

// File: rtl/vid_dpath.sv
module vid_dpath
  import vid_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dpCmd_t          dpCmd,
  input  logic [ID_W-1:0] reqWdata,
  input  logic [ID_W-1:0] physId,
  output logic [ID_W-1:0] rspRdata
);
  localparam int HALF_W = ID_W / 2;

  logic [ID_W-1:0] virtReg;
  logic [ID_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) virtReg <= fixBits(physId);
    else if (dpCmd.wrEn) virtReg <= fixBits(reqWdata);
  end

  always_comb begin
    case (dpCmd.rdSel)
      RS_VIRT:    rdNext = virtReg;
      RS_PHYS:    rdNext = physId;
      RS_VIRT_LO: rdNext = {{HALF_W{1'b0}}, virtReg[HALF_W-1:0]};
      RS_PHYS_LO: rdNext = {{HALF_W{1'b0}}, physId[HALF_W-1:0]};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspRdata <= '0;
    else rspRdata <= rdNext;
  end
endmodule

// File: rtl/vid_access_ctl.sv
module vid_access_ctl
  import vid_pkg::*;
#(
  parameter int CLASS_W = 6,
  parameter int OFF_W = 12,
  parameter logic [OFF_W-1:0] MEM_OFF = 12'h050
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqCp32,
  input  logic [15:0]        reqEnc,
  input  logic               reqWrite,
  input  logic [63:0]        reqWdata,
  input  logic [1:0]         curEl,
  input  logic               hypImpl,
  input  logic               hypEnabled,
  input  logic               hyp32,
  input  logic               nvBit,
  input  logic               nv2Bit,
  input  logic               tgeBit,
  input  logic               fgtRead,
  input  logic               el3Impl,
  input  logic               fgtEnable,
  input  logic               idTrapFeat,
  input  logic               cpTrap,
  input  logic [63:0]        physId,
  output logic               rspValid,
  output logic [2:0]         rspCode,
  output logic [63:0]        rspRdata,
  output logic [1:0]         rspTargetEl,
  output logic [CLASS_W-1:0] rspClass,
  output logic [OFF_W-1:0]   rspMemOff
);
  dpCmd_t dpCmd;

  vid_ctrl #(.CLASS_W(CLASS_W), .OFF_W(OFF_W), .MEM_OFF(MEM_OFF)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCp32(reqCp32),
    .reqEnc(reqEnc), .reqWrite(reqWrite), .curEl(curEl), .hypImpl(hypImpl),
    .hypEnabled(hypEnabled), .hyp32(hyp32), .nvBit(nvBit), .nv2Bit(nv2Bit),
    .tgeBit(tgeBit), .fgtRead(fgtRead), .el3Impl(el3Impl), .fgtEnable(fgtEnable),
    .idTrapFeat(idTrapFeat), .cpTrap(cpTrap), .dpCmd(dpCmd),
    .rspValid(rspValid), .rspCode(rspCode), .rspTargetEl(rspTargetEl),
    .rspClass(rspClass), .rspMemOff(rspMemOff)
  );

  vid_dpath u_dpath (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .reqWdata(reqWdata),
    .physId(physId), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/vid_access_chk.sv
module vid_access_chk
  import vid_pkg::*;
#(
  parameter int CLASS_W = 6,
  parameter int OFF_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqCp32,
  input logic [15:0]        reqEnc,
  input logic               reqWrite,
  input logic [1:0]         curEl,
  input logic               hypEnabled,
  input logic               nvBit,
  input logic               nv2Bit,
  input logic [63:0]        physId,
  input logic               rspValid,
  input logic [2:0]         rspCode,
  input logic [63:0]        rspRdata,
  input logic [1:0]         rspTargetEl,
  input logic [CLASS_W-1:0] rspClass,
  input logic [OFF_W-1:0]   rspMemOff
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rspValid == $past(reqValid)));

  // R1
  quiet_rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != OC_DATA) |-> (rspRdata == '0));

  // R4
  virt_el0_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqCp32 && reqEnc == ENC_VIRT && curEl == 2'd0) |=> (rspCode == OC_UNDEF));

  // R5
  nested_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqCp32 && reqEnc == ENC_VIRT && curEl == 2'd1 && hypEnabled && nvBit && nv2Bit)
      |=> (rspCode == OC_MEM && rspMemOff == 12'h050));

  // R13
  phys_high_el_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqCp32 && !reqWrite && reqEnc == ENC_PHYS && curEl[1])
      |=> (rspCode == OC_DATA && rspRdata == $past(physId)));

  // R6
  trap_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == OC_TRAP) |-> (rspTargetEl != 2'd0 && rspTargetEl != 2'd3));
endmodule

bind vid_access_ctl vid_access_chk #(.CLASS_W(CLASS_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCp32(reqCp32), .reqEnc(reqEnc),
  .reqWrite(reqWrite), .curEl(curEl), .hypEnabled(hypEnabled), .nvBit(nvBit),
  .nv2Bit(nv2Bit), .physId(physId), .rspValid(rspValid), .rspCode(rspCode),
  .rspRdata(rspRdata), .rspTargetEl(rspTargetEl), .rspClass(rspClass),
  .rspMemOff(rspMemOff)
);

// File: tb/vid_access_ctl_tb.sv
module vid_access_ctl_tb;
  typedef struct {
    logic [2:0]  code;
    logic [63:0] rdata;
    logic [1:0]  tgt;
    logic [5:0]  cls;
    logic [11:0] off;
    string       req;
  } item_t;

  localparam logic [15:0] E_VIRT = 16'hE005;
  localparam logic [15:0] E_PHYS = 16'hC005;
  localparam logic [15:0] E_CP   = 16'h0005;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqCp32 = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqEnc = '0;
  logic [63:0] reqWdata = '0;
  logic [1:0] curEl = '0;
  logic hypImpl, hypEnabled, hyp32, nvBit, nv2Bit, tgeBit, fgtRead, el3Impl, fgtEnable, idTrapFeat, cpTrap;
  logic [63:0] physId = 64'hABCD_EF12_3E00_0304;
  logic rspValid;
  logic [2:0] rspCode;
  logic [63:0] rspRdata;
  logic [1:0] rspTargetEl;
  logic [5:0] rspClass;
  logic [11:0] rspMemOff;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t expQ[$];
  logic [63:0] vExp;

  always #2 clk = ~clk;

  vid_access_ctl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCp32(reqCp32), .reqEnc(reqEnc),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .curEl(curEl), .hypImpl(hypImpl),
    .hypEnabled(hypEnabled), .hyp32(hyp32), .nvBit(nvBit), .nv2Bit(nv2Bit),
    .tgeBit(tgeBit), .fgtRead(fgtRead), .el3Impl(el3Impl), .fgtEnable(fgtEnable),
    .idTrapFeat(idTrapFeat), .cpTrap(cpTrap), .physId(physId), .rspValid(rspValid),
    .rspCode(rspCode), .rspRdata(rspRdata), .rspTargetEl(rspTargetEl),
    .rspClass(rspClass), .rspMemOff(rspMemOff)
  );

  function automatic logic [63:0] clean(input logic [63:0] v);
    logic [63:0] r;
    r = v;
    r[63:40] = '0;
    r[29:25] = '0;
    r[31] = 1'b1;
    return r;
  endfunction

  task automatic defaults();
    hypImpl = 1; hypEnabled = 1; hyp32 = 0; nvBit = 0; nv2Bit = 0; tgeBit = 0;
    fgtRead = 0; el3Impl = 1; fgtEnable = 0; idTrapFeat = 0; cpTrap = 0;
  endtask

  task automatic issue(input logic [15:0] enc, input logic cp, input logic wr,
                       input logic [63:0] wd, input logic [1:0] el,
                       input logic [2:0] code, input logic [63:0] rd,
                       input logic [1:0] tgt, input logic [5:0] cls,
                       input logic [11:0] off, input string req);
    item_t it;
    @(negedge clk);
    reqValid = 1; reqEnc = enc; reqCp32 = cp; reqWrite = wr; reqWdata = wd; curEl = el;
    it.code = code; it.rdata = rd; it.tgt = tgt; it.cls = cls; it.off = off; it.req = req;
    expQ.push_back(it);
    @(negedge clk);
    reqValid = 0;
  endtask

  // monitor: compare each response with the oldest expected item
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      item_t it;
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected response code %0d, expected none", rspCode);
      end else begin
        it = expQ.pop_front();
        if (rspCode != it.code || rspRdata != it.rdata ||
            (it.code == 3'd4 && (rspTargetEl != it.tgt || rspClass != it.cls)) ||
            (it.code == 3'd3 && rspMemOff != it.off)) begin
          fails++;
          $display("FAIL %s: code=%0d rdata=%h tgt=%0d cls=%h off=%h, expected code=%0d rdata=%h tgt=%0d cls=%h off=%h",
                   it.req, rspCode, rspRdata, rspTargetEl, rspClass, rspMemOff,
                   it.code, it.rdata, it.tgt, it.cls, it.off);
        end
      end
    end
  end

  task automatic finish_run();
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d responses missing, expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1: watchdog expired, run incomplete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset rspValid=%b expected 0", rspValid);
    end
    rstN = 1;
    // R3 reset value with fixed bits applied
    vExp = clean(physId);
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, vExp, 0, 0, 0, "R3");
    // R2 R7 all-ones and all-zeros writes
    issue(E_VIRT, 0, 1, '1, 2'd2, 3'd1, 0, 0, 0, 0, "R7");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, 64'h0000_00FF_C1FF_FFFF, 0, 0, 0, "R2");
    issue(E_VIRT, 0, 1, 0, 2'd2, 3'd1, 0, 0, 0, 0, "R7");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, 64'h0000_0000_8000_0000, 0, 0, 0, "R2");
    vExp = 64'h0000_0033_C102_0105;
    issue(E_VIRT, 0, 1, 64'h0000_0033_4102_0105, 2'd2, 3'd1, 0, 0, 0, 0, "R7");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, vExp, 0, 0, 0, "R7");
    // R4 level 0 and unmatched encodings
    issue(E_VIRT, 0, 0, 0, 2'd0, 3'd5, 0, 0, 0, 0, "R4");
    issue(E_VIRT, 0, 1, '1, 2'd0, 3'd5, 0, 0, 0, 0, "R4");
    issue(16'hE006, 0, 0, 0, 2'd2, 3'd5, 0, 0, 0, 0, "R4");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, vExp, 0, 0, 0, "R4");
    // R5 redirect, register unchanged
    nvBit = 1; nv2Bit = 1;
    issue(E_VIRT, 0, 1, '1, 2'd1, 3'd3, 0, 0, 0, 12'h050, "R5");
    issue(E_VIRT, 0, 0, 0, 2'd1, 3'd3, 0, 0, 0, 12'h050, "R5");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, vExp, 0, 0, 0, "R5");
    // R6 trap and undefined at level 1
    nv2Bit = 0;
    issue(E_VIRT, 0, 0, 0, 2'd1, 3'd4, 0, 2'd2, 6'h18, 0, "R6");
    nvBit = 0; nv2Bit = 1;
    issue(E_VIRT, 0, 0, 0, 2'd1, 3'd5, 0, 0, 0, 0, "R6");
    nvBit = 1; hypEnabled = 0;
    issue(E_VIRT, 0, 0, 0, 2'd1, 3'd5, 0, 0, 0, 0, "R6");
    defaults();
    // R8 level 3
    hypImpl = 0;
    issue(E_VIRT, 0, 0, 0, 2'd3, 3'd0, physId, 0, 0, 0, "R8");
    issue(E_VIRT, 0, 1, 0, 2'd3, 3'd2, 0, 0, 0, 0, "R8");
    hypImpl = 1;
    issue(E_VIRT, 0, 0, 0, 2'd3, 3'd0, vExp, 0, 0, 0, "R8");
    vExp = 64'h0000_0044_8000_0007;
    issue(E_VIRT, 0, 1, 64'h0000_0044_0000_0007, 2'd3, 3'd1, 0, 0, 0, 0, "R8");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, vExp, 0, 0, 0, "R8");
    // R9 R10 physical reads at level 1
    fgtRead = 1;
    issue(E_PHYS, 0, 0, 0, 2'd1, 3'd0, vExp, 0, 0, 0, "R10");
    fgtEnable = 1;
    issue(E_PHYS, 0, 0, 0, 2'd1, 3'd4, 0, 2'd2, 6'h18, 0, "R9");
    fgtEnable = 0; el3Impl = 0;
    issue(E_PHYS, 0, 0, 0, 2'd1, 3'd4, 0, 2'd2, 6'h18, 0, "R9");
    hyp32 = 1;
    issue(E_PHYS, 0, 0, 0, 2'd1, 3'd0, physId, 0, 0, 0, "R10");
    defaults(); hypEnabled = 0;
    issue(E_PHYS, 0, 0, 0, 2'd1, 3'd0, physId, 0, 0, 0, "R10");
    defaults();
    // R11 level 0 physical reads
    issue(E_PHYS, 0, 0, 0, 2'd0, 3'd5, 0, 0, 0, 0, "R11");
    idTrapFeat = 1;
    issue(E_PHYS, 0, 0, 0, 2'd0, 3'd4, 0, 2'd1, 6'h18, 0, "R11");
    tgeBit = 1;
    issue(E_PHYS, 0, 0, 0, 2'd0, 3'd4, 0, 2'd2, 6'h18, 0, "R11");
    hyp32 = 1;
    issue(E_PHYS, 0, 0, 0, 2'd0, 3'd4, 0, 2'd1, 6'h18, 0, "R11");
    defaults();
    // R12 coprocessor reads
    cpTrap = 1;
    issue(E_CP, 1, 0, 0, 2'd1, 3'd4, 0, 2'd2, 6'h03, 0, "R12");
    cpTrap = 0;
    issue(E_CP, 1, 0, 0, 2'd1, 3'd0, {32'h0, vExp[31:0]}, 0, 0, 0, "R12");
    hypEnabled = 0; cpTrap = 1;
    issue(E_CP, 1, 0, 0, 2'd1, 3'd0, {32'h0, physId[31:0]}, 0, 0, 0, "R12");
    defaults();
    issue(E_CP, 1, 0, 0, 2'd2, 3'd0, {32'h0, physId[31:0]}, 0, 0, 0, "R12");
    // R13 high-level physical reads and illegal writes
    issue(E_PHYS, 0, 0, 0, 2'd2, 3'd0, physId, 0, 0, 0, "R13");
    issue(E_PHYS, 0, 0, 0, 2'd3, 3'd0, physId, 0, 0, 0, "R13");
    issue(E_PHYS, 0, 1, '1, 2'd2, 3'd5, 0, 0, 0, 0, "R13");
    issue(E_CP, 1, 1, '1, 2'd1, 3'd5, 0, 0, 0, 0, "R13");
    issue(E_VIRT, 0, 0, 0, 2'd2, 3'd0, vExp, 0, 0, 0, "R13");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule